// File: doc/BRIEF.md
# Parallel Programming Port Controller

This block sits inside a microcontroller and serves its parallel programming port. All pins are sampled on the internal clock. The block first watches the reset, enable and byte-select pins for the sequence that arms programming mode. It rejects that sequence if byte-select moves while the mode is settling.

Once armed, a rising edge on the strobe pin loads the 8-bit data bus into one of three places, chosen by a two-bit action code: the address pair, the data pair or the command register. For the address and data pairs, byte-select picks the high or the low half. The stored command is classified as known or unknown. A chip-erase command is carried out only after a long enough low pulse on the write pin. It then drives a short request sequence towards the memory arrays and lock bits.

The ready/busy output is held high, because erasing never signals busy.

Top module: `parProgCtrl`

## Requirements
- R1: After the internal reset `rstN` is released, `progMode` is 0, the address, data and command outputs are 0, `cmdValid` and all three erase requests are 0, and `readyBusy` is 1.
- R2: Programming mode is armed only when all of these hold, and then `progMode` becomes 1. First, `enPin`, `resetPin` and `bytePin` are low together for at least `SETUP_CYC` consecutive clock cycles. Next, `resetPin` is raised. Then `bytePin` holds its level for `GUARD_CYC` cycles. A shorter low phase leaves `progMode` at 0.
- R3: Any change of `bytePin` within the guard window after `resetPin` rises aborts entry, and `progMode` stays 0.
- R4: While in programming mode, each rising edge of `strobePin` acts according to the `actCode` bits. Code 00 loads an address byte. Code 01 loads a data byte. Code 10 loads the command byte. Code 11 changes nothing.
- R5: For address and data loads, `bytePin`=1 writes bits 15:8 of the target pair and `bytePin`=0 writes bits 7:0.
- R6: While `progMode` is 0, strobe and write pulses change no output. On each entry into programming mode, the address, data and command registers and `cmdValid` are cleared to 0.
- R7: `cmdValid` is 1 after a command load only for the bytes 0x80, 0x20, 0x10, 0x11, 0x08, 0x04, 0x02 and 0x03. For any other byte it is 0.
- R8: Suppose the stored command is 0x80 and valid, and a low pulse on `wrN` lasts at least `MIN_WR_CYC` cycles. When that pulse ends, `eraseArrays` is high for one cycle. In the next cycle `clearLocks` is high for one cycle. In the cycle after that `eraseDone` is high for one cycle. At most one of the three is high at any time.
- R9: A `wrN` low pulse shorter than `MIN_WR_CYC`, or any pulse while the stored command is not a valid 0x80, starts no erase.
- R10: `readyBusy` stays 1 through an erase sequence.
- R11: Driving `resetPin` low while in programming mode makes `progMode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Internal reset, active low |
| enPin | input | 1 | Programming enable pin, must be low for entry |
| resetPin | input | 1 | External reset pin of the port |
| bytePin | input | 1 | Byte select: high/low half and entry guard |
| actCode | input | 2 | Action code applied on each strobe |
| strobePin | input | 1 | Load strobe, acts on rising edge |
| wrN | input | 1 | Write pin, active low |
| dataBus | input | 8 | Byte bus from the programmer |
| progMode | output | 1 | Programming mode armed |
| addrOut | output | 16 | Address pair |
| dataOut | output | 16 | Data pair |
| cmdOut | output | 8 | Stored command |
| cmdValid | output | 1 | Stored command is a known code |
| eraseArrays | output | 1 | Request: erase flash and EEPROM arrays |
| clearLocks | output | 1 | Request: clear lock bits |
| eraseDone | output | 1 | Erase sequence finished |
| readyBusy | output | 1 | Ready/busy pin, high means ready |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- An entry attempt with too short a low phase, and one where byte-select toggles in the guard window. A design that skips either test would arm the mode when it should stay out.
- Loads and write pulses issued before entry, followed by an entry. A design that ignores the mode or fails to clear on entry would show a stale command.
- A write pulse a few cycles below the minimum, and a long pulse under a non-erase command. These catch an erase that a weak width or command check lets through.
- A full erase, timed at each cycle for request order and single-cycle width. This catches lock bits cleared before the arrays.

// File: rtl/parProgPkg.sv
package parProgPkg;
  typedef enum logic [1:0] {ACT_ADDR = 2'b00, ACT_DATA = 2'b01, ACT_CMD = 2'b10, ACT_NONE = 2'b11} actCodeT;
  typedef enum logic [1:0] {MODE_OFF, MODE_GUARD, MODE_ON} modeStT;
  typedef enum logic [1:0] {ER_IDLE, ER_ARRAYS, ER_LOCKS, ER_DONE} eraseStT;

  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic loadCmd;
    logic hiSel;
    logic clearAll;
  } dpCtrlT;

  localparam logic [7:0] CMD_ERASE = 8'h80;

  function automatic logic isKnownCmd(input logic [7:0] code);
    case (code)
      8'h80, 8'h20, 8'h10, 8'h11, 8'h08, 8'h04, 8'h02, 8'h03: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/parProgDatapath.sv
module parProgDatapath
  import parProgPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrlT              ctl,
  input  logic [BYTE_W-1:0]   dataBus,
  output logic [2*BYTE_W-1:0] addrQ,
  output logic [2*BYTE_W-1:0] dataQ,
  output logic [BYTE_W-1:0]   cmdQ,
  output logic                validQ
);
  localparam int PAIR_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] busSample;

  // bus sampled in the same cycle the control samples the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busSample <= '0;
    else       busSample <= dataBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      cmdQ   <= '0;
      validQ <= 1'b0;
    end else if (ctl.clearAll) begin
      addrQ  <= '0;
      dataQ  <= '0;
      cmdQ   <= '0;
      validQ <= 1'b0;
    end else begin
      if (ctl.loadAddr) begin
        if (ctl.hiSel) addrQ[PAIR_W-1:BYTE_W] <= busSample;
        else           addrQ[BYTE_W-1:0]      <= busSample;
      end
      if (ctl.loadData) begin
        if (ctl.hiSel) dataQ[PAIR_W-1:BYTE_W] <= busSample;
        else           dataQ[BYTE_W-1:0]      <= busSample;
      end
      if (ctl.loadCmd) begin
        cmdQ   <= busSample;
        validQ <= isKnownCmd(busSample);
      end
    end
  end

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadAddr || ctl.loadData || ctl.loadCmd || ctl.clearAll) |=> $stable({addrQ, dataQ, cmdQ, validQ})); // R6
endmodule

// File: rtl/parProgControl.sv
module parProgControl
  import parProgPkg::*;
#(
  parameter int SETUP_CYC  = 20,
  parameter int GUARD_CYC  = 20,
  parameter int MIN_WR_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       resetPin,
  input  logic       bytePin,
  input  logic [1:0] actCode,
  input  logic       strobePin,
  input  logic       wrN,
  input  logic [7:0] cmdQ,
  input  logic       cmdValid,
  output dpCtrlT     ctl,
  output logic       modeOn,
  output logic       eraseArrays,
  output logic       clearLocks,
  output logic       eraseDone
);
  localparam int LOW_W   = $clog2(SETUP_CYC + 1);
  localparam int GUARD_W = $clog2(GUARD_CYC + 1);
  localparam int WR_W    = $clog2(MIN_WR_CYC + 1);

  logic       sEn, sRst, sBs, sStb, sWr;
  logic       pRst, pBs, pStb, pWr;
  logic [1:0] sAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sEn, sRst, sBs, sStb, sWr} <= 5'b01001;
      {pRst, pBs, pStb, pWr}      <= 4'b1001;
      sAct                        <= 2'b11;
    end else begin
      {sEn, sRst, sBs, sStb, sWr} <= {enPin, resetPin, bytePin, strobePin, wrN};
      {pRst, pBs, pStb, pWr}      <= {sRst, sBs, sStb, sWr};
      sAct                        <= actCode;
    end
  end

  // mode entry
  modeStT           modeSt;
  logic [LOW_W-1:0]   lowCnt;
  logic [GUARD_W-1:0] guardCnt;
  logic               enterNow;

  assign enterNow = (modeSt == MODE_GUARD) && sRst && (sBs == pBs) &&
                    (guardCnt == GUARD_W'(GUARD_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSt   <= MODE_OFF;
      lowCnt   <= '0;
      guardCnt <= '0;
    end else begin
      if (!sEn && !sRst && !sBs) begin
        if (lowCnt != LOW_W'(SETUP_CYC)) lowCnt <= lowCnt + 1'b1;
      end else begin
        lowCnt <= '0;
      end
      case (modeSt)
        MODE_OFF: begin
          guardCnt <= '0;
          if (sRst && !pRst && (lowCnt == LOW_W'(SETUP_CYC))) modeSt <= MODE_GUARD;
        end
        MODE_GUARD: begin
          if (!sRst || (sBs != pBs)) modeSt <= MODE_OFF;
          else if (enterNow)         modeSt <= MODE_ON;
          else                       guardCnt <= guardCnt + 1'b1;
        end
        MODE_ON:  if (!sRst) modeSt <= MODE_OFF;
        default:  modeSt <= MODE_OFF;
      endcase
    end
  end

  assign modeOn = (modeSt == MODE_ON);

  // load strobes
  logic stbRise;
  assign stbRise      = modeOn && sStb && !pStb;
  assign ctl.loadAddr = stbRise && (sAct == ACT_ADDR);
  assign ctl.loadData = stbRise && (sAct == ACT_DATA);
  assign ctl.loadCmd  = stbRise && (sAct == ACT_CMD);
  assign ctl.hiSel    = sBs;
  assign ctl.clearAll = enterNow;

  // write pulse width and erase sequence
  eraseStT         erSt;
  logic [WR_W-1:0] wrCnt;
  logic            startErase;

  assign startErase = modeOn && sWr && !pWr && (wrCnt == WR_W'(MIN_WR_CYC)) &&
                      cmdValid && (cmdQ == CMD_ERASE) && (erSt == ER_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt <= '0;
      erSt  <= ER_IDLE;
    end else begin
      if (modeOn && !sWr) begin
        if (wrCnt != WR_W'(MIN_WR_CYC)) wrCnt <= wrCnt + 1'b1;
      end else begin
        wrCnt <= '0;
      end
      case (erSt)
        ER_IDLE:   if (startErase) erSt <= ER_ARRAYS;
        ER_ARRAYS: erSt <= ER_LOCKS;
        ER_LOCKS:  erSt <= ER_DONE;
        default:   erSt <= ER_IDLE;
      endcase
    end
  end

  assign eraseArrays = (erSt == ER_ARRAYS);
  assign clearLocks  = (erSt == ER_LOCKS);
  assign eraseDone   = (erSt == ER_DONE);

  AST_ARRAYS_THEN_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    eraseArrays |=> clearLocks); // R8
  AST_LOCKS_AFTER_ARRAYS: assert property (@(posedge clk) disable iff (!rstN)
    clearLocks |-> $past(eraseArrays)); // R8
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseArrays, clearLocks, eraseDone})); // R8
  AST_ERASE_IN_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseArrays) |-> $past(modeOn) && $past(cmdQ) == CMD_ERASE); // R9
  AST_NO_LOAD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !modeOn |-> !(ctl.loadAddr || ctl.loadData || ctl.loadCmd)); // R6
endmodule

// File: rtl/parProgCtrl.sv
module parProgCtrl
  import parProgPkg::*;
#(
  parameter int SETUP_CYC  = 20,
  parameter int GUARD_CYC  = 20,
  parameter int MIN_WR_CYC = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enPin,
  input  logic        resetPin,
  input  logic        bytePin,
  input  logic [1:0]  actCode,
  input  logic        strobePin,
  input  logic        wrN,
  input  logic [7:0]  dataBus,
  output logic        progMode,
  output logic [15:0] addrOut,
  output logic [15:0] dataOut,
  output logic [7:0]  cmdOut,
  output logic        cmdValid,
  output logic        eraseArrays,
  output logic        clearLocks,
  output logic        eraseDone,
  output logic        readyBusy
);
  dpCtrlT dpCtl;

  parProgControl #(
    .SETUP_CYC (SETUP_CYC),
    .GUARD_CYC (GUARD_CYC),
    .MIN_WR_CYC(MIN_WR_CYC)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .enPin      (enPin),
    .resetPin   (resetPin),
    .bytePin    (bytePin),
    .actCode    (actCode),
    .strobePin  (strobePin),
    .wrN        (wrN),
    .cmdQ       (cmdOut),
    .cmdValid   (cmdValid),
    .ctl        (dpCtl),
    .modeOn     (progMode),
    .eraseArrays(eraseArrays),
    .clearLocks (clearLocks),
    .eraseDone  (eraseDone)
  );

  parProgDatapath #(.BYTE_W(8)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (dpCtl),
    .dataBus(dataBus),
    .addrQ  (addrOut),
    .dataQ  (dataOut),
    .cmdQ   (cmdOut),
    .validQ (cmdValid)
  );

  // erase never reports busy
  assign readyBusy = 1'b1;
endmodule

// File: tb/parProgCtrl_bench.sv
`timescale 1ns/1ps
module parProgCtrl_bench;
  localparam int SETUP_CYC  = 20;
  localparam int GUARD_CYC  = 20;
  localparam int MIN_WR_CYC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPin = 1'b1, resetPin = 1'b1, bytePin = 1'b0, strobePin = 1'b0, wrN = 1'b1;
  logic [1:0] actCode = 2'b11;
  logic [7:0] dataBus = 8'h00;
  logic progMode, cmdValid, eraseArrays, clearLocks, eraseDone, readyBusy;
  logic [15:0] addrOut, dataOut;
  logic [7:0] cmdOut;

  always #2.5 clk = ~clk;

  parProgCtrl #(.SETUP_CYC(SETUP_CYC), .GUARD_CYC(GUARD_CYC), .MIN_WR_CYC(MIN_WR_CYC)) u_parProgCtrl (
    .clk(clk), .rstN(rstN), .enPin(enPin), .resetPin(resetPin), .bytePin(bytePin),
    .actCode(actCode), .strobePin(strobePin), .wrN(wrN), .dataBus(dataBus),
    .progMode(progMode), .addrOut(addrOut), .dataOut(dataOut), .cmdOut(cmdOut),
    .cmdValid(cmdValid), .eraseArrays(eraseArrays), .clearLocks(clearLocks),
    .eraseDone(eraseDone), .readyBusy(readyBusy)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // request monitor, sampled mid-cycle
  int eaCnt = 0, clCnt = 0, dnCnt = 0, orderBad = 0, multiHot = 0, rbLow = 0;
  logic prevEa = 1'b0, prevCl = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (eraseArrays) eaCnt++;
      if (clearLocks) clCnt++;
      if (eraseDone) dnCnt++;
      if (clearLocks && !prevEa) orderBad++;
      if (eraseDone && !prevCl) orderBad++;
      if ((32'(eraseArrays) + 32'(clearLocks) + 32'(eraseDone)) > 1) multiHot++;
      if (!readyBusy) rbLow++;
      prevEa = eraseArrays;
      prevCl = clearLocks;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enterMode(input int lowCycles, input bit toggleBs);
    @(negedge clk);
    enPin = 1'b0; resetPin = 1'b0; bytePin = 1'b0;
    waitCyc(lowCycles);
    resetPin = 1'b1;
    if (toggleBs) begin
      waitCyc(4);
      bytePin = 1'b1;
    end
    waitCyc(GUARD_CYC + 6);
    bytePin = 1'b0;
    waitCyc(2);
  endtask

  task automatic strobeLoad(input logic [1:0] act, input logic bs, input logic [7:0] d);
    @(negedge clk);
    actCode = act; bytePin = bs; dataBus = d;
    waitCyc(2);
    strobePin = 1'b1;
    waitCyc(2);
    strobePin = 1'b0;
    waitCyc(3);
    bytePin = 1'b0;
  endtask

  task automatic wrPulse(input int n);
    @(negedge clk);
    wrN = 1'b0;
    waitCyc(n);
    wrN = 1'b1;
    waitCyc(8);
  endtask

  // act, bs, bus byte, expected addr, data, cmd, valid after the load
  typedef struct packed {
    logic [1:0]  act;
    logic        bs;
    logic [7:0]  d;
    logic [15:0] expAddr;
    logic [15:0] expData;
    logic [7:0]  expCmd;
    logic        expValid;
  } vecT;

  localparam int NVEC = 10;
  localparam vecT VECS [NVEC] = '{
    '{2'b00, 1'b0, 8'h34, 16'h0034, 16'h0000, 8'h00, 1'b0},
    '{2'b00, 1'b1, 8'h12, 16'h1234, 16'h0000, 8'h00, 1'b0},
    '{2'b01, 1'b0, 8'hCD, 16'h1234, 16'h00CD, 8'h00, 1'b0},
    '{2'b01, 1'b1, 8'hAB, 16'h1234, 16'hABCD, 8'h00, 1'b0},
    '{2'b11, 1'b1, 8'hFF, 16'h1234, 16'hABCD, 8'h00, 1'b0},
    '{2'b10, 1'b0, 8'h11, 16'h1234, 16'hABCD, 8'h11, 1'b1},
    '{2'b10, 1'b0, 8'h55, 16'h1234, 16'hABCD, 8'h55, 1'b0},
    '{2'b10, 1'b1, 8'h03, 16'h1234, 16'hABCD, 8'h03, 1'b1},
    '{2'b00, 1'b0, 8'h99, 16'h1299, 16'hABCD, 8'h03, 1'b1},
    '{2'b10, 1'b0, 8'h80, 16'h1299, 16'hABCD, 8'h80, 1'b1}
  };

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    check(progMode == 0 && addrOut == 0 && dataOut == 0 && cmdOut == 0 && !cmdValid, "R1 reset regs",
          {progMode, addrOut, dataOut, cmdOut, cmdValid}, 0);
    check({eraseArrays, clearLocks, eraseDone} == 0 && readyBusy == 1, "R1 reset requests",
          {eraseArrays, clearLocks, eraseDone, readyBusy}, 1);

    // R6 loads and writes before entry are ignored
    enPin = 1'b0;
    strobeLoad(2'b10, 1'b0, 8'h80);
    wrPulse(MIN_WR_CYC + 4);
    check(cmdOut == 0 && !cmdValid, "R6 load outside mode", cmdOut, 0);
    check(eaCnt == 0, "R6 write outside mode", eaCnt, 0);

    // R2 low phase too short
    enterMode(5, 1'b0);
    check(progMode == 0, "R2 short low phase", progMode, 0);
    resetPin = 1'b0; waitCyc(2);

    // R3 byte select toggles in guard window
    enterMode(SETUP_CYC + 4, 1'b1);
    check(progMode == 0, "R3 guard toggle", progMode, 0);

    // R2 good entry, R6 registers zero
    enterMode(SETUP_CYC + 4, 1'b0);
    check(progMode == 1, "R2 entry", progMode, 1);
    check(addrOut == 0 && dataOut == 0 && cmdOut == 0, "R6 clear on entry", {addrOut, dataOut, cmdOut}, 0);

    // R4 R5 R7 table walk
    for (int i = 0; i < NVEC; i++) begin
      strobeLoad(VECS[i].act, VECS[i].bs, VECS[i].d);
      check(addrOut == VECS[i].expAddr && dataOut == VECS[i].expData &&
            cmdOut == VECS[i].expCmd && cmdValid == VECS[i].expValid,
            $sformatf("R4 R5 R7 vector %0d", i),
            {addrOut, dataOut, cmdOut, 7'b0, cmdValid},
            {VECS[i].expAddr, VECS[i].expData, VECS[i].expCmd, 7'b0, VECS[i].expValid});
    end

    // R9 short write pulse ignored
    wrPulse(MIN_WR_CYC - 4);
    check(eaCnt == 0, "R9 short pulse", eaCnt, 0);

    // R8 R10 full erase
    wrPulse(MIN_WR_CYC + 3);
    check(eaCnt == 1 && clCnt == 1 && dnCnt == 1, "R8 one cycle each",
          {eaCnt[15:0], clCnt[15:0], dnCnt[15:0]}, {16'd1, 16'd1, 16'd1});
    check(orderBad == 0 && multiHot == 0, "R8 order", {orderBad, multiHot}, 0);
    check(rbLow == 0, "R10 ready/busy quiet", rbLow, 0);

    // R9 non-erase command with long pulse
    strobeLoad(2'b10, 1'b0, 8'h10);
    wrPulse(MIN_WR_CYC + 6);
    check(eaCnt == 1, "R9 other command", eaCnt, 1);

    // R11 leave mode, then R6 reentry clears
    strobeLoad(2'b10, 1'b0, 8'h80);
    @(negedge clk); resetPin = 1'b0; waitCyc(3);
    check(progMode == 0, "R11 exit", progMode, 0);
    check(cmdOut == 8'h80, "R6 regs hold after exit", cmdOut, 8'h80);
    wrPulse(MIN_WR_CYC + 4);
    check(eaCnt == 1, "R6 write after exit", eaCnt, 1);
    enterMode(SETUP_CYC + 4, 1'b0);
    check(progMode == 1 && cmdOut == 0 && !cmdValid, "R6 reentry clears", {progMode, cmdOut, cmdValid}, 10'h200);

    summary();
  end
endmodule